// File: doc/BRIEF.md
# Video Fetch Bus Cycle Arbiter

This block decides, for every bus cycle of a 63-cycle raster line, who owns the second half of that cycle on the shared memory bus. The first half always belongs to the video engine. The second half normally belongs to the CPU. The video engine claims whole cycles in two cases. It claims two cycles for each enabled sprite, at fixed slots. On a bad line it claims forty cycles to fetch the character pointers.

Three cycles before a claim, the block drops a bus-available warning. Writes the CPU issues during that warning still complete. The first read, or internal cycle, stalls the CPU until the warning ends. When a claim directly follows another claim, no new warning is inserted. This also holds across the line boundary.

The raster cycle number comes from the video timing generator, which counts 1 to 63. The bad-line condition is a level input. The block latches it and clears it at the end of each line.

Top module: `vdma_bus_arbiter`

## Requirements
- R1: With no sprite enabled and no bad-line condition, `bus_free_o` and `cpu_grant_o` stay 1 and `cpu_hold_o` stays 0 for all 63 cycles of the line.
- R2: When enabled, sprite n with n in 0..2 claims cycles 58+2n and 59+2n. Sprite n with n in 3..7 claims cycles 2n-5 and 2n-4 of the line.
- R3: `bus_free_o` is 0 in every claimed cycle and in each of the three cycles before one. In the warning cycles that are not claimed, `cpu_grant_o` stays 1.
- R4: `cpu_grant_o` is 0 in exactly the claimed cycles, and `cpu_hold_o` is 1 in every claimed cycle.
- R5: Claims that lie within three cycles of each other share one low period of `bus_free_o`. This includes sprite 2 at cycles 62/63 running into sprite 3 at cycles 1/2.
- R6: If the bad-line input is 1 at cycle 12, the warning covers cycles 12 to 14 and the character claim covers cycles 15 to 54. With reads only, this leaves 20 free cycles.
- R7: If the bad-line input first becomes 1 at a cycle c in 13..54, the warning covers c..c+2 and the claim covers c+3 up to c+42, capped at cycle 63.
- R8: In a warning cycle, a write (`cpu_rd_i`=0) is not held. The first read holds the CPU, and the hold stays on until `bus_free_o` returns to 1, even if writes follow. On a bad line with writes in cycles 12..14, 23 cycles stay free.
- R9: The latched bad-line state clears at cycle 63. A condition that first appears after cycle 54 has no effect on that line.
- R10: `cpu_hold_o` is 0 whenever `bus_free_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_cyc_i | input | 6 | Current cycle in the line, 1..63 |
| badline_i | input | 1 | Bad-line condition level |
| spr_en_i | input | 8 | Sprite fetch enables, bit n for sprite n |
| cpu_rd_i | input | 1 | CPU cycle type: 1 read or internal, 0 write |
| bus_free_o | output | 1 | Bus-available warning, 0 from three cycles before a claim |
| cpu_grant_o | output | 1 | 1 when the CPU owns the second half-cycle |
| cpu_hold_o | output | 1 | 1 when the CPU is stalled in this cycle |

## Verification
The bench runs whole lines and compares all three outputs in every cycle against a schedule computed from the slot positions. It also compares the number of unheld cycles per line against an arithmetic count.

The sprite sets tested are: none, sprite 0 alone, sprites 0 and 7 together, sprites 2 and 3, and all eight. These separate a single warning, two separate warnings, a warning shared across the line wrap, and one merged block.

Bad lines are tried with the condition present early, at cycle 17, at cycle 30 (clipped at line end), and at cycle 58 (ignored). These cases show the fixed start, the shifted start, clipping, and the line-end clear. Read/write mixes inside a warning show that writes complete, that the first read holds, and that the hold persists.

// File: rtl/abm_pkg.sv
package abm_pkg;

    localparam int LINE_LEN    = 63;
    localparam int CYC_W       = 6;
    localparam int WARN_LEN    = 3;
    localparam int NUM_SPR     = 8;
    localparam int SPR_SLOT    = 2;
    localparam int SPR_PREV    = 3;
    localparam int CHAR_LEN    = 40;
    localparam int BL_EARLY    = 12;
    localparam int BL_LATE_MAX = 54;
    localparam int SPR_PREV_BASE = LINE_LEN - SPR_PREV * SPR_SLOT + 1;
    localparam int LOOK        = WARN_LEN + 1;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef struct packed {
        logic warn_low;
        logic claim;
    } sched_t;

    function automatic int spr_first(input int n);
        if (n < SPR_PREV)
            return SPR_PREV_BASE + SPR_SLOT * n;
        return 1 + SPR_SLOT * (n - SPR_PREV);
    endfunction

endpackage

// File: rtl/abm_slot_table.sv
module abm_slot_table
    import abm_pkg::*;
(
    input  cyc_t               pos,
    input  logic               next_line,
    input  logic [NUM_SPR-1:0] spr_en,
    input  cyc_t               bl_start,
    output logic               hit
);
    logic [NUM_SPR-1:0] spr_hit;

    for (genvar n = 0; n < NUM_SPR; n++) begin : g_spr
        localparam cyc_t FIRST = cyc_t'(spr_first(n));
        localparam cyc_t LAST  = cyc_t'(spr_first(n) + SPR_SLOT - 1);
        assign spr_hit[n] = spr_en[n] && (pos >= FIRST) && (pos <= LAST);
    end

    logic [7:0] p8, s8;
    logic       bl_hit;
    assign p8 = {2'b00, pos};
    assign s8 = {2'b00, bl_start};
    assign bl_hit = (bl_start != '0) && !next_line
                  && (p8 >= s8 + 8'(WARN_LEN))
                  && (p8 <  s8 + 8'(WARN_LEN + CHAR_LEN));

    assign hit = bl_hit || (|spr_hit);
endmodule

// File: rtl/abm_lookahead.sv
module abm_lookahead
    import abm_pkg::*;
(
    input  cyc_t               cyc,
    input  logic [NUM_SPR-1:0] spr_en,
    input  cyc_t               bl_start,
    output sched_t             sched
);
    logic [LOOK-1:0] hits;

    for (genvar k = 0; k < LOOK; k++) begin : g_ahead
        logic [CYC_W:0] sum;
        logic           wrapped;
        cyc_t           pos;
        assign sum     = {1'b0, cyc} + (CYC_W+1)'(k);
        assign wrapped = sum > (CYC_W+1)'(LINE_LEN);
        assign pos     = wrapped ? cyc_t'(sum - (CYC_W+1)'(LINE_LEN)) : cyc_t'(sum);

        abm_slot_table u_tab (
            .pos       (pos),
            .next_line (wrapped),
            .spr_en    (spr_en),
            .bl_start  (bl_start),
            .hit       (hits[k])
        );
    end

    assign sched.claim    = hits[0];
    assign sched.warn_low = |hits;
endmodule

// File: rtl/abm_badline.sv
module abm_badline
    import abm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cyc_t cyc,
    input  logic bl_cond,
    output cyc_t bl_start
);
    cyc_t q, start_now;

    assign start_now = (bl_cond && cyc >= cyc_t'(BL_EARLY) && cyc <= cyc_t'(BL_LATE_MAX))
                     ? cyc : '0;
    assign bl_start  = (q != '0) ? q : start_now;

    always_ff @(posedge clk) begin
        if (rst)                        q <= '0;
        else if (cyc == cyc_t'(LINE_LEN)) q <= '0;
        else if (q == '0)               q <= start_now;
    end

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (q != '0 && cyc != cyc_t'(LINE_LEN)) |=> $stable(q));
    a_r9_line_clear: assert property (@(posedge clk) disable iff (rst)
        (cyc == cyc_t'(LINE_LEN)) |=> (q == '0));
    a_r7_start_window: assert property (@(posedge clk) disable iff (rst)
        (q != '0) |-> (q >= cyc_t'(BL_EARLY) && q <= cyc_t'(BL_LATE_MAX)));
endmodule

// File: rtl/abm_stall.sv
module abm_stall
    import abm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sched_t sched,
    input  logic   cpu_rd,
    output logic   hold
);
    logic held_q;

    assign hold = sched.warn_low && (cpu_rd || held_q || sched.claim);

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= sched.warn_low && hold;
    end

    a_r8_hold_persists: assert property (@(posedge clk) disable iff (rst)
        (hold && sched.warn_low) |=> (!sched.warn_low || hold));
    a_r8_write_passes: assert property (@(posedge clk) disable iff (rst)
        (!held_q && !cpu_rd && !sched.claim) |-> !hold);
endmodule

// File: rtl/vdma_bus_arbiter.sv
module vdma_bus_arbiter
    import abm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CYC_W-1:0]   raster_cyc_i,
    input  logic               badline_i,
    input  logic [NUM_SPR-1:0] spr_en_i,
    input  logic               cpu_rd_i,
    output logic               bus_free_o,
    output logic               cpu_grant_o,
    output logic               cpu_hold_o
);
    cyc_t   bl_start;
    sched_t sched;

    abm_badline u_bl (
        .clk      (clk),
        .rst      (rst),
        .cyc      (raster_cyc_i),
        .bl_cond  (badline_i),
        .bl_start (bl_start)
    );

    abm_lookahead u_ahead (
        .cyc      (raster_cyc_i),
        .spr_en   (spr_en_i),
        .bl_start (bl_start),
        .sched    (sched)
    );

    abm_stall u_stall (
        .clk    (clk),
        .rst    (rst),
        .sched  (sched),
        .cpu_rd (cpu_rd_i),
        .hold   (cpu_hold_o)
    );

    assign bus_free_o  = !sched.warn_low;
    assign cpu_grant_o = !sched.claim;

    a_r10_free_no_hold: assert property (@(posedge clk) disable iff (rst)
        bus_free_o |-> !cpu_hold_o);
    a_r4_claim_holds: assert property (@(posedge clk) disable iff (rst)
        !cpu_grant_o |-> (cpu_hold_o && !bus_free_o));
endmodule

// File: tb/sim_vdma_bus_arbiter.sv
module sim_vdma_bus_arbiter;
    logic       clk = 0, rst = 1;
    logic [5:0] cyc = 6'd1;
    logic       bl = 0, rd = 1;
    logic [7:0] en = 0;
    logic       ba, aec, hold;
    int checks = 0, fails = 0;
    bit done = 0;
    bit held_e = 0;

    always #2.5 clk = ~clk;

    vdma_bus_arbiter u0 (
        .clk(clk), .rst(rst), .raster_cyc_i(cyc), .badline_i(bl),
        .spr_en_i(en), .cpu_rd_i(rd),
        .bus_free_o(ba), .cpu_grant_o(aec), .cpu_hold_o(hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_claim(input int x, input bit nxt, input logic [7:0] e, input int st);
        for (int n = 0; n < 8; n++) begin
            int f = (n < 3) ? 58 + 2*n : 2*n - 5;
            if (e[n] && (x == f || x == f + 1)) return 1;
        end
        if (!nxt && st != 0 && x >= st + 3 && x <= st + 42) return 1;
        return 0;
    endfunction

    task automatic run_line(input string tag, input logic [7:0] e, input int bl_from,
                            input logic [63:0] wmask, input int exp_free);
        int st, free;
        st = (bl_from == 0) ? 0 : (bl_from <= 12) ? 12 : (bl_from <= 54) ? bl_from : 0;
        free = 0;
        for (int c = 1; c <= 63; c++) begin
            bit wl, tk, se;
            @(posedge clk); #1;
            cyc = 6'(c);
            en  = e;
            bl  = (bl_from != 0) && (c >= bl_from);
            rd  = !wmask[c];
            wl = 0;
            for (int k = 0; k <= 3; k++) begin
                int x = c + k;
                bit nx = x > 63;
                if (nx) x -= 63;
                if (m_claim(x, nx, e, st)) wl = 1;
            end
            tk = m_claim(c, 0, e, st);
            se = wl && (rd || held_e || tk);
            @(negedge clk);
            check({tag, " R3/R5 bus_free"}, ba, !wl);
            check({tag, " R4/R2 grant"}, aec, !tk);
            check({tag, " R8/R10 hold"}, hold, se);
            held_e = wl && se;
            if (!hold) free++;
        end
        check({tag, " free cycles"}, free, exp_free);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 reset bus_free", ba, 1);
        check("R1 reset grant", aec, 1);
        check("R1 reset hold", hold, 0);

        run_line("R1 idle",            8'h00, 0,  64'h0, 63);
        run_line("R2 sprite0",         8'h01, 0,  64'h0, 58);
        run_line("R2 sprite0+7",       8'h81, 0,  64'h0, 53);
        run_line("R5 sprite2+3 wrap",  8'h0C, 0,  64'h0, 56);
        run_line("R5 all sprites",     8'hFF, 0,  64'h0, 44);
        run_line("R6 normal badline",  8'h00, 5,  64'h0, 20);
        run_line("R8 badline writes",  8'h00, 12, (64'h1 << 12) | (64'h1 << 13) | (64'h1 << 14), 23);
        run_line("R7 late 17",         8'h00, 17, 64'h0, 20);
        run_line("R7 late 30 capped",  8'h00, 30, 64'h0, 29);
        run_line("R9 cleared",         8'h00, 0,  64'h0, 63);
        run_line("R9 too late",        8'h00, 58, 64'h0, 63);
        run_line("R8 write write read",8'h01, 0,  (64'h1 << 55) | (64'h1 << 56), 60);
        run_line("R8 read then writes",8'h01, 0,  (64'h1 << 56) | (64'h1 << 57), 58);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule